// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block steers a DDR2 memory device into self-refresh and back out. Software starts entry with a one-cycle request strobe. The sequencer then drives the clock-enable pin low. After a programmable settling count it raises a status bit that software can poll. While that status bit is high, software may stop the memory clock with a separate disable bit. The sequencer never gates the clock on its own.

An internal access to memory space wakes the device. The device must first have stayed in self-refresh for a programmable minimum residency count. The sequencer then raises clock-enable and waits one of two programmable delays before it grants the access. The long delay applies to a read, because the memory DLL must relock. The short delay applies to a write. If an access arrives while the clock is stopped, it is refused with a one-cycle bus error and the device stays asleep.

Each delay rule below is a count N, and the wait it produces lasts max(N,1) clock cycles.

Top module: `srf_sequencer`

## Requirements
- R1: While reset is held, and right after it, cke is 1, mem_clk_en is 1, sr_active is 0, bus_err is 0 and acc_gnt is 0.
- R2: In the idle state, a clock edge that samples srf_req=1 while acc_req=0 drives cke to 0 at that edge. sr_active rises max(t_enter,1) cycles after cke falls.
- R3: While sr_active is 1, cke stays 0. With no permitted access, the device stays in self-refresh for any length of time.
- R4: A permitted access (acc_req=1 with clk_off=0) in self-refresh ends it: cke rises and sr_active falls at the same clock edge.
- R5: After cke rises at exit, acc_gnt stays 0 and then rises exactly max(t_xsrd,1) cycles later when acc_rd=1 (read). It rises exactly max(t_xsnr,1) cycles later when acc_rd=0 (write). A t_xsrd of 200 gives a wait of 200 cycles.
- R6: Count the clock edges since sr_active rose. An access first sampled at edge h is held pending, and exit happens at edge max(max(t_ras,1), h).
- R7: mem_clk_en is 0 exactly when clk_off=1 and sr_active=1. Outside self-refresh, clk_off has no effect on mem_clk_en or cke.
- R8: In self-refresh with clk_off=1, an access raises bus_err for exactly one cycle, starting at the edge that samples it. cke stays 0, sr_active stays 1 and acc_gnt stays 0.
- R9: In the idle state, acc_gnt follows acc_req. An entry request that arrives while acc_req=1 is held, and cke falls at the first edge that samples acc_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srf_req | input | 1 | One-cycle software strobe asking for self-refresh entry |
| clk_off | input | 1 | Software bit that stops the memory clock during self-refresh |
| acc_req | input | 1 | Internal access to memory space, held until granted or refused |
| acc_rd | input | 1 | 1 = the access is a read, 0 = a write |
| t_enter | input | CNT_W | Cycles from clock-enable low to status high |
| t_ras | input | CNT_W | Minimum self-refresh residency in cycles |
| t_xsnr | input | CNT_W | Exit wait before a write |
| t_xsrd | input | CNT_W | Exit wait before a read (DLL relock) |
| cke | output | 1 | Memory clock-enable pin |
| mem_clk_en | output | 1 | Enable for the memory clock gate |
| sr_active | output | 1 | Self-refresh status for software polling |
| bus_err | output | 1 | One-cycle refusal of an access made while the clock is stopped |
| acc_gnt | output | 1 | Access may proceed |

## Verification
The bench goes after the off-by-one edges of every wait. A counter that loaded N and used N+1 cycles, or that treated zero as a huge wait, would move cke, sr_active or acc_gnt one cycle away from the bench's computed edge. Picking the wrong exit delay for reads or writes would show up as a grant at the other count. It also sends accesses early, during the residency window: a design that exits at once breaks R6, and one that drops the pending access never wakes. Refused accesses while the clock is stopped must leave the device asleep with a single error pulse; a design that still wakes, or that repeats the error, is caught. An entry request made during an access must wait for that access to end.

// File: rtl/srf_pkg.sv
package srf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ENTER = 2'd1,
      ST_SREF  = 2'd2,
      ST_EXIT  = 2'd3
   } srf_state_e;
endpackage

// File: rtl/srf_downcnt.sv
module srf_downcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last_o
);
   logic [W-1:0] cnt;

   // saturating down counter; "last" means zero or one cycle remains
   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign last_o = (cnt[W-1:1] == '0);
endmodule

// File: rtl/srf_clkgate.sv
module srf_clkgate #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_off,
   input  logic sr_active,
   output logic clk_en
);
   generate
      if (REG_OUT) begin : g_reg
         logic en_q;
         always_ff @(posedge clk) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= !(clk_off && sr_active);
         end
         assign clk_en = en_q;
      end else begin : g_comb
         assign clk_en = !(clk_off && sr_active);
      end
   endgenerate
endmodule

// File: rtl/srf_fsm.sv
module srf_fsm
   import srf_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srf_req,
   input  logic         clk_off,
   input  logic         acc_req,
   input  logic         acc_rd,
   input  logic [W-1:0] t_enter,
   input  logic [W-1:0] t_ras,
   input  logic [W-1:0] t_xsnr,
   input  logic [W-1:0] t_xsrd,
   input  logic         cnt_last,
   output logic         cnt_load,
   output logic [W-1:0] cnt_val,
   output logic         cke,
   output logic         sr_active,
   output logic         bus_err,
   output logic         acc_gnt
);
   srf_state_e state, nxt;
   logic       pend;
   logic       want_entry;

   assign want_entry = srf_req || pend;

   always_comb begin
      nxt      = state;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state)
         ST_IDLE: if (want_entry && !acc_req) begin
            nxt      = ST_ENTER;
            cnt_load = 1'b1;
            cnt_val  = t_enter;
         end
         ST_ENTER: if (cnt_last) begin
            nxt      = ST_SREF;
            cnt_load = 1'b1;
            cnt_val  = t_ras;
         end
         ST_SREF: if (cnt_last && acc_req && !clk_off) begin
            nxt      = ST_EXIT;
            cnt_load = 1'b1;
            cnt_val  = acc_rd ? t_xsrd : t_xsnr;
         end
         ST_EXIT: if (cnt_last) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= 1'b0;
         cke       <= 1'b1;
         sr_active <= 1'b0;
         bus_err   <= 1'b0;
      end else begin
         state     <= nxt;
         pend      <= (state == ST_IDLE) && want_entry && acc_req;
         cke       <= (nxt == ST_IDLE) || (nxt == ST_EXIT);
         sr_active <= (nxt == ST_SREF);
         bus_err   <= (state == ST_SREF) && acc_req && clk_off && !bus_err;
      end
   end

   assign acc_gnt = (state == ST_IDLE) && acc_req;

   // R3: status high means clock-enable is low
   p_status_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |-> !cke);
   // R8: error is a single-cycle pulse
   p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> !bus_err);
   // R8: refused access leaves the device asleep
   p_err_keeps_sref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (sr_active && !cke && !acc_gnt));
   // R5: grant only with the device awake
   p_gnt_awake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_gnt |-> (cke && !sr_active));
   // R4: clock-enable rises only when leaving self-refresh
   p_exit_from_sref_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> $past(sr_active));
   // R9: entry never overlaps an access
   p_entry_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> !$past(acc_req));
endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer #(
   parameter int CNT_W      = 16,
   parameter bit GATE_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srf_req,
   input  logic             clk_off,
   input  logic             acc_req,
   input  logic             acc_rd,
   input  logic [CNT_W-1:0] t_enter,
   input  logic [CNT_W-1:0] t_ras,
   input  logic [CNT_W-1:0] t_xsnr,
   input  logic [CNT_W-1:0] t_xsrd,
   output logic             cke,
   output logic             mem_clk_en,
   output logic             sr_active,
   output logic             bus_err,
   output logic             acc_gnt
);
   localparam int MIN_W = 8;   // must hold a 200-cycle relock wait
   localparam int MAX_W = 32;

   generate
      if (CNT_W < MIN_W || CNT_W > MAX_W) begin : g_bad_width
         $error("srf_sequencer: CNT_W out of range");
      end
   endgenerate

   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_last;

   srf_fsm #(.W(CNT_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .srf_req   (srf_req),
      .clk_off   (clk_off),
      .acc_req   (acc_req),
      .acc_rd    (acc_rd),
      .t_enter   (t_enter),
      .t_ras     (t_ras),
      .t_xsnr    (t_xsnr),
      .t_xsrd    (t_xsrd),
      .cnt_last  (cnt_last),
      .cnt_load  (cnt_load),
      .cnt_val   (cnt_val),
      .cke       (cke),
      .sr_active (sr_active),
      .bus_err   (bus_err),
      .acc_gnt   (acc_gnt)
   );

   srf_downcnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .last_o   (cnt_last)
   );

   srf_clkgate #(.REG_OUT(GATE_REG)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_off   (clk_off),
      .sr_active (sr_active),
      .clk_en    (mem_clk_en)
   );

   // R7: the clock is never stopped while the device is awake
   p_gate_in_sref_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_clk_en) |-> !cke);
endmodule

// File: tb/sim_srf_sequencer.sv
module sim_srf_sequencer;
   localparam int CLK_P = 10;
   localparam int CW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          srf_req = 1'b0, clk_off = 1'b0, acc_req = 1'b0, acc_rd = 1'b0;
   logic [CW-1:0] t_enter = '0, t_ras = '0, t_xsnr = '0, t_xsrd = '0;
   logic          cke, mem_clk_en, sr_active, bus_err, acc_gnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   srf_sequencer #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .srf_req(srf_req), .clk_off(clk_off),
      .acc_req(acc_req), .acc_rd(acc_rd), .t_enter(t_enter), .t_ras(t_ras),
      .t_xsnr(t_xsnr), .t_xsrd(t_xsrd), .cke(cke), .mem_clk_en(mem_clk_en),
      .sr_active(sr_active), .bus_err(bus_err), .acc_gnt(acc_gnt)
   );

   function automatic int wait_of(int n);
      return (n == 0) ? 1 : n;
   endfunction

   function automatic int exit_edge(int ras, int h);
      int m = wait_of(ras);
      return (h > m) ? h : m;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic episode(int ent, int ras, int xsnr, int xsrd, bit rd,
                          bit early, bit do_err, bit defer, int extra);
      int n;
      int h;
      int exp_e;
      t_enter = CW'(ent); t_ras = CW'(ras); t_xsnr = CW'(xsnr); t_xsrd = CW'(xsrd);
      // R7: clk_off has no effect while awake
      clk_off = 1'b1;
      #1;
      chk(mem_clk_en == 1'b1, "R7 awake gate", mem_clk_en, 1);
      tick();
      chk(cke == 1'b1, "R7 awake cke", cke, 1);
      clk_off = 1'b0;
      if (defer) begin
         acc_req = 1'b1; srf_req = 1'b1;
         #1;
         chk(acc_gnt == 1'b1, "R9 idle grant", acc_gnt, 1);
         tick(); srf_req = 1'b0;
         chk(cke == 1'b1, "R9 held entry", cke, 1);
         tick();
         chk(cke == 1'b1, "R9 held entry", cke, 1);
         acc_req = 1'b0;
         tick();
         chk(cke == 1'b0, "R9 entry after access", cke, 0);
      end else begin
         srf_req = 1'b1;
         tick(); srf_req = 1'b0;
         chk(cke == 1'b0, "R2 cke low", cke, 0);
      end
      n = 0;
      while (!sr_active && n < 100000) begin tick(); n++; end
      chk(n == wait_of(ent), "R2 status delay", n, wait_of(ent));
      h = 0;
      if (do_err) begin
         clk_off = 1'b1; acc_req = 1'b1; acc_rd = rd;
         #1;
         chk(mem_clk_en == 1'b0, "R7 gate off", mem_clk_en, 0);
         tick(); h++;
         chk(bus_err == 1'b1, "R8 error raised", bus_err, 1);
         chk(cke == 1'b0 && sr_active && !acc_gnt, "R8 stays asleep", cke, 0);
         acc_req = 1'b0;
         tick(); h++;
         chk(bus_err == 1'b0, "R8 error one cycle", bus_err, 0);
         chk(sr_active == 1'b1, "R8 status kept", sr_active, 1);
         clk_off = 1'b0;
         #1;
         chk(mem_clk_en == 1'b1, "R7 gate on", mem_clk_en, 1);
      end
      if (!early) begin
         while (h < wait_of(ras) + extra) begin tick(); h++; end
         chk(sr_active && !cke, "R3 residency held", sr_active, 1);
      end
      acc_req = 1'b1; acc_rd = rd;
      exp_e = exit_edge(ras, h + 1);
      while (!cke && h < 100000) begin tick(); h++; end
      chk(h == exp_e, "R6 exit edge", h, exp_e);
      chk(sr_active == 1'b0, "R4 status falls with cke", sr_active, 0);
      n = 0;
      while (!acc_gnt && n < 100000) begin
         if (!cke) chk(1'b0, "R5 cke during exit", cke, 1);
         tick(); n++;
      end
      exp_e = wait_of(rd ? xsrd : xsnr);
      chk(n == exp_e, rd ? "R5 read wait" : "R5 write wait", n, exp_e);
      tick();
      chk(acc_gnt == 1'b1, "R9 grant follows request", acc_gnt, 1);
      acc_req = 1'b0;
      #1;
      chk(acc_gnt == 1'b0, "R9 grant drops", acc_gnt, 0);
      tick();
   endtask

   initial begin
      int seed;
      seed = 32'd20240607;
      void'($urandom(seed));
      tick();
      chk(cke == 1'b1 && mem_clk_en == 1'b1, "R1 reset pins", cke, 1);
      chk(!sr_active && !bus_err && !acc_gnt, "R1 reset status", sr_active, 0);
      tick();
      rst_n = 1'b1;
      tick();
      chk(cke == 1'b1 && !sr_active && !acc_gnt, "R1 after reset", cke, 1);
      // directed corners
      episode(3, 5, 2, 200, 1'b1, 1'b0, 1'b0, 1'b0, 4);   // 200-cycle read relock
      episode(0, 0, 0, 0,   1'b0, 1'b1, 1'b0, 1'b0, 0);   // all zero counts
      episode(1, 1, 1, 1,   1'b1, 1'b1, 1'b1, 1'b0, 0);   // error then early
      episode(2, 20, 7, 9,  1'b0, 1'b1, 1'b0, 1'b1, 0);   // early wake, deferred entry
      episode(4, 2, 6, 3,   1'b0, 1'b0, 1'b1, 1'b0, 3);   // error after residency
      for (int i = 0; i < 40; i++) begin
         episode($urandom_range(0, 12), $urandom_range(0, 30),
                 $urandom_range(0, 25), $urandom_range(0, 60),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 10));
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule